// File: doc/BRIEF.md
# Three-Phase Offset-Centred PWM Gate Timer

This block produces the upper-switch gate commands for a three-phase inverter bridge from three signed per-phase reference samples. It avoids any sector decoding. Each phase reference is multiplied by a scale factor to give a signed imaginary switching time. The spread between the largest and smallest of these times is the active window. A single offset is added to all three times so that this window sits in the middle of the sampling period. The shifted times are clamped to the period and then compared against a free-running period counter.

Successive periods alternate between two sequences. In the falling sequence every gate starts high and drops once the count reaches its time. In the rising sequence the stored time is mirrored against the period, so every gate rises late and stays high to the end. Each pair of periods therefore carries the same widths, laid out mirror-image about the boundary between the two periods. References are captured on a strobe. New references, the scale and the period length take effect only at the next period boundary.

Top module: `svpwm_gate_timer`

## Requirements
- R1: While `rstN` is low, all three gates are low and `seqOn` is 0. The first period after reset is a falling sequence (`seqOn` = 0).
- R2: The imaginary time of a phase is t = floor(ref * scale / 2^SHIFT), with `ref` signed and `scale` unsigned. With the default SHIFT = 8, a negative reference gives a negative time.
- R3: The per-period pulse width of a phase is tMin-relative: w = t - tMin + floor((P - (tMax - tMin)) / 2), where P is the period length. Unclamped widths of any two phases therefore differ by exactly their imaginary-time difference.
- R4: When w would fall below 0 it is 0, and when w would exceed P it is P.
- R5: In a falling sequence (`seqOn` = 0), a gate is high exactly while the period count (0 to P-1) is below its width. A gate that has gone low stays low for the rest of that period.
- R6: In a rising sequence (`seqOn` = 1), a gate is high exactly while the count is at or above P - w. It stays high once risen, so the two periods of a pair carry equal widths.
- R7: `seqOn` toggles at every period boundary and at no other time.
- R8: `sampleStrobe` captures the three references. The captured references, `scale` and `periodLen` are used only at the next period boundary, so a strobe or a change of `scale` or `periodLen` during a period leaves that period's gates unchanged.
- R9: A period lasts exactly P clock cycles, with P taken from `periodLen` at the boundary that starts it. P must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | Captures refA/refB/refC this cycle |
| refA | input | REF_W | Phase A reference, signed |
| refB | input | REF_W | Phase B reference, signed |
| refC | input | REF_W | Phase C reference, signed |
| scale | input | SCALE_W | Unsigned time scale, fixed point with SHIFT fraction bits |
| periodLen | input | PER_W | Sampling period length in clock cycles |
| gateA | output | 1 | Phase A upper-switch command |
| gateB | output | 1 | Phase B upper-switch command |
| gateC | output | 1 | Phase C upper-switch command |
| seqOn | output | 1 | 0 in a falling sequence, 1 in a rising sequence |

## Verification
The gates are a same-cycle function of the registered count, the stored times and `seqOn`, so a gate reflects count value k in the cycle the counter holds k. A strobe registered on edge n reaches the gates only in the first period that starts after edge n. The period boundary itself is the edge on which the count wraps to 0, which is also when `seqOn` flips. The bench therefore keeps a behavioural model that advances on each rising edge and compares every gate and `seqOn` at the following falling edge. Directed checks strobe new references well inside a period and then measure whole periods: widths, first and last cycle levels, and period lengths derived from `seqOn` transitions.

// File: rtl/svpwm_pkg.sv
`timescale 1ns/1ps
package svpwm_pkg;
  localparam int NPH = 3;

  // Strobes from control to datapath, valid in the cycle before a new period
  typedef struct packed {
    logic load;    // period boundary: latch new gating times
    logic nextOn;  // sequence of the period that starts at this boundary
  } svpwm_strobe_t;
endpackage

// File: rtl/svpwm_ctrl.sv
`timescale 1ns/1ps
module svpwm_ctrl
  import svpwm_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PER_W-1:0] periodLen,
  output svpwm_strobe_t    strobe,
  output logic [PER_W-1:0] count,
  output logic [PER_W-1:0] activePeriod,
  output logic             seqOn
);
  localparam int CW = PER_W + 1;

  logic primed;
  logic wrap;

  always_comb begin
    wrap          = primed && ((CW'(count) + CW'(1)) >= CW'(activePeriod));
    strobe.load   = !primed || wrap;
    strobe.nextOn = seqOn ^ wrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      activePeriod <= '0;
      seqOn        <= 1'b0;
      primed       <= 1'b0;
    end else if (strobe.load) begin
      count        <= '0;
      activePeriod <= periodLen;
      seqOn        <= strobe.nextOn;
      primed       <= 1'b1;
    end else begin
      count <= count + PER_W'(1);
    end
  end
endmodule

// File: rtl/svpwm_phase_lane.sv
`timescale 1ns/1ps
module svpwm_phase_lane
  import svpwm_pkg::*;
#(
  parameter int REF_W   = 12,
  parameter int SCALE_W = 8,
  parameter int PER_W   = 12,
  parameter int SHIFT   = 8,
  parameter int EW      = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REF_W-1:0] refVal,
  input  logic [SCALE_W-1:0]      scale,
  input  logic signed [EW-1:0]    offset,
  input  logic [PER_W-1:0]        periodLen,
  input  svpwm_strobe_t           strobe,
  input  logic [PER_W-1:0]        count,
  input  logic                    seqOn,
  output logic signed [EW-1:0]    tImag,
  output logic                    gate
);
  localparam int TW = REF_W + SCALE_W + 1;

  logic signed [TW-1:0] prod;
  logic signed [TW-1:0] scaled;
  logic signed [EW-1:0] tShift;
  logic signed [EW-1:0] pExt;
  logic [PER_W-1:0]     tgSat;
  logic [PER_W-1:0]     nextTime;
  logic [PER_W-1:0]     active;

  // Scaling, shift by the common offset, clamp, and mirror for rising sequences
  always_comb begin
    prod   = TW'(refVal) * $signed(TW'({1'b0, scale}));
    scaled = prod >>> SHIFT;
    tImag  = EW'(scaled);
    pExt   = $signed(EW'(periodLen));
    tShift = tImag + offset;
    if (tShift < 0)
      tgSat = '0;
    else if (tShift > pExt)
      tgSat = periodLen;
    else
      tgSat = tShift[PER_W-1:0];
    nextTime = strobe.nextOn ? (periodLen - tgSat) : tgSat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      active <= '0;
    else if (strobe.load)
      active <= nextTime;
  end

  always_comb begin
    if (seqOn)
      gate = (count >= active);
    else
      gate = (count < active);
  end
endmodule

// File: rtl/svpwm_datapath.sv
`timescale 1ns/1ps
module svpwm_datapath
  import svpwm_pkg::*;
#(
  parameter int REF_W   = 12,
  parameter int SCALE_W = 8,
  parameter int PER_W   = 12,
  parameter int SHIFT   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStrobe,
  input  logic signed [REF_W-1:0] refIn [NPH],
  input  logic [SCALE_W-1:0]      scale,
  input  logic [PER_W-1:0]        periodLen,
  input  svpwm_strobe_t           strobe,
  input  logic [PER_W-1:0]        count,
  input  logic                    seqOn,
  output logic [NPH-1:0]          gates
);
  localparam int TW = REF_W + SCALE_W + 1;
  localparam int EW = ((TW > PER_W) ? TW : PER_W) + 3;

  logic signed [REF_W-1:0] refHold [NPH];
  logic signed [EW-1:0]    tImag   [NPH];
  logic signed [EW-1:0]    tMin;
  logic signed [EW-1:0]    tMax;
  logic signed [EW-1:0]    tEff;
  logic signed [EW-1:0]    tZero;
  logic signed [EW-1:0]    pExt;
  logic signed [EW-1:0]    offset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPH; i++) refHold[i] <= '0;
    end else if (sampleStrobe) begin
      for (int i = 0; i < NPH; i++) refHold[i] <= refIn[i];
    end
  end

  // Active window and the offset that centres it in the period
  always_comb begin
    tMin = tImag[0];
    tMax = tImag[0];
    for (int i = 1; i < NPH; i++) begin
      if (tImag[i] < tMin) tMin = tImag[i];
      if (tImag[i] > tMax) tMax = tImag[i];
    end
    pExt   = $signed(EW'(periodLen));
    tEff   = tMax - tMin;
    tZero  = pExt - tEff;
    offset = (tZero >>> 1) - tMin;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_lane
    svpwm_phase_lane #(
      .REF_W  (REF_W),
      .SCALE_W(SCALE_W),
      .PER_W  (PER_W),
      .SHIFT  (SHIFT),
      .EW     (EW)
    ) lane_i (
      .clk      (clk),
      .rstN     (rstN),
      .refVal   (refHold[g]),
      .scale    (scale),
      .offset   (offset),
      .periodLen(periodLen),
      .strobe   (strobe),
      .count    (count),
      .seqOn    (seqOn),
      .tImag    (tImag[g]),
      .gate     (gates[g])
    );
  end
endmodule

// File: rtl/svpwm_gate_timer.sv
`timescale 1ns/1ps
module svpwm_gate_timer
  import svpwm_pkg::*;
#(
  parameter int REF_W   = 12,
  parameter int SCALE_W = 8,
  parameter int PER_W   = 12,
  parameter int SHIFT   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStrobe,
  input  logic signed [REF_W-1:0] refA,
  input  logic signed [REF_W-1:0] refB,
  input  logic signed [REF_W-1:0] refC,
  input  logic [SCALE_W-1:0]      scale,
  input  logic [PER_W-1:0]        periodLen,
  output logic                    gateA,
  output logic                    gateB,
  output logic                    gateC,
  output logic                    seqOn
);
  svpwm_strobe_t           strobe;
  logic [PER_W-1:0]        count;
  logic [PER_W-1:0]        activePeriod;
  logic signed [REF_W-1:0] refArr [NPH];
  logic [NPH-1:0]          gates;

  assign refArr[0] = refA;
  assign refArr[1] = refB;
  assign refArr[2] = refC;
  assign gateA = gates[0];
  assign gateB = gates[1];
  assign gateC = gates[2];

  svpwm_ctrl #(.PER_W(PER_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .periodLen   (periodLen),
    .strobe      (strobe),
    .count       (count),
    .activePeriod(activePeriod),
    .seqOn       (seqOn)
  );

  svpwm_datapath #(
    .REF_W  (REF_W),
    .SCALE_W(SCALE_W),
    .PER_W  (PER_W),
    .SHIFT  (SHIFT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleStrobe(sampleStrobe),
    .refIn       (refArr),
    .scale       (scale),
    .periodLen   (periodLen),
    .strobe      (strobe),
    .count       (count),
    .seqOn       (seqOn),
    .gates       (gates)
  );
endmodule

// File: rtl/svpwm_gate_timer_chk.sv
`timescale 1ns/1ps
module svpwm_gate_timer_chk #(
  parameter int PER_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       gates,
  input logic             seqOn,
  input logic [PER_W-1:0] count,
  input logic [PER_W-1:0] activePeriod,
  input logic             load,
  input logic             nextOn
);
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_low_R1: assert (gates == 3'b000 && !seqOn);
    end
  end

  assert_count_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (activePeriod != '0) |-> (count < activePeriod));

  assert_period_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(activePeriod));

  assert_seq_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (seqOn == $past(nextOn)));

  assert_seq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(seqOn));

  assert_falling_no_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!seqOn && !load) |=> ((gates & ~$past(gates)) == 3'b000));

  assert_rising_no_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (seqOn && !load) |=> ((~gates & $past(gates)) == 3'b000));
endmodule

bind svpwm_gate_timer svpwm_gate_timer_chk #(.PER_W(PER_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .gates       ({gateC, gateB, gateA}),
  .seqOn       (seqOn),
  .count       (count),
  .activePeriod(activePeriod),
  .load        (strobe.load),
  .nextOn      (strobe.nextOn)
);

// File: tb/svpwm_gate_timer_tb_top.sv
`timescale 1ns/1ps
module svpwm_gate_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic signed [11:0] refA = '0;
  logic signed [11:0] refB = '0;
  logic signed [11:0] refC = '0;
  logic [7:0]  scale = 8'd128;
  logic [11:0] periodLen = 12'd100;
  logic gateA, gateB, gateC, seqOn;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  svpwm_gate_timer dut_i (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .refA(refA), .refB(refB), .refC(refC),
    .scale(scale), .periodLen(periodLen),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .seqOn(seqOn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Imaginary times and clamped widths straight from the requirements
  function automatic void calcTimes(input int r[3], input int sc, input int p,
                                    output int t[3], output int w[3]);
    int mn, mx, half;
    for (int i = 0; i < 3; i++) t[i] = (r[i] * sc) >>> 8;
    mn = t[0]; mx = t[0];
    for (int i = 1; i < 3; i++) begin
      if (t[i] < mn) mn = t[i];
      if (t[i] > mx) mx = t[i];
    end
    half = (p - (mx - mn)) >>> 1;
    for (int i = 0; i < 3; i++) begin
      w[i] = t[i] - mn + half;
      if (w[i] < 0) w[i] = 0;
      if (w[i] > p) w[i] = p;
    end
  endfunction

  // Behavioural cycle model
  int mCount = 0, mPer = 0, mSeq = 0, mPrimed = 0;
  int mAct[3] = '{0, 0, 0};
  int mHold[3] = '{0, 0, 0};

  always @(posedge clk or negedge rstN) begin
    int tt[3], ww[3];
    int boundary, nOn;
    if (!rstN) begin
      mCount = 0; mPer = 0; mSeq = 0; mPrimed = 0;
      for (int i = 0; i < 3; i++) begin mAct[i] = 0; mHold[i] = 0; end
    end else begin
      boundary = (mPrimed != 0 && mCount + 1 >= mPer) ? 1 : 0;
      if (mPrimed == 0 || boundary != 0) begin
        nOn = boundary != 0 ? 1 - mSeq : mSeq;
        calcTimes(mHold, int'(scale), int'(periodLen), tt, ww);
        for (int i = 0; i < 3; i++) mAct[i] = (nOn != 0) ? int'(periodLen) - ww[i] : ww[i];
        mCount = 0; mPer = int'(periodLen); mSeq = nOn; mPrimed = 1;
      end else begin
        mCount++;
      end
      if (sampleStrobe) begin
        mHold[0] = int'(refA); mHold[1] = int'(refB); mHold[2] = int'(refC);
      end
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    bit g[3];
    bit e;
    g[0] = gateA; g[1] = gateB; g[2] = gateC;
    for (int i = 0; i < 3; i++) begin
      e = (mSeq != 0) ? (mCount >= mAct[i]) : (mCount < mAct[i]);
      if (!rstN) check(g[i] == 1'b0, "R1", "gate low in reset", int'(g[i]), 0);
      else if (mSeq != 0) check(g[i] == e, "R6", "rising-sequence gate", int'(g[i]), int'(e));
      else check(g[i] == e, "R5", "falling-sequence gate", int'(g[i]), int'(e));
    end
    check(int'(seqOn) == mSeq, "R7", "sequence flag", int'(seqOn), mSeq);
  end

  task automatic strobeRefs(input int a, input int b, input int c);
    @(negedge clk);
    while (mCount != 5) @(negedge clk);
    refA = 12'(a); refB = 12'(b); refC = 12'(c);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  // Measure one whole period; optionally strobe new refs and scale at count 40
  task automatic measure(output int w[3], output int first[3], output int last[3],
                         output int seq, input bit midStrobe,
                         input int na, input int nb, input int nc, input int nsc);
    int len;
    bit g[3];
    while (mCount != 0) @(negedge clk);
    len = mPer; seq = int'(seqOn);
    for (int i = 0; i < 3; i++) w[i] = 0;
    for (int c = 0; c < len; c++) begin
      g[0] = gateA; g[1] = gateB; g[2] = gateC;
      for (int i = 0; i < 3; i++) begin
        w[i] += int'(g[i]);
        if (c == 0) first[i] = int'(g[i]);
        if (c == len - 1) last[i] = int'(g[i]);
      end
      if (midStrobe && c == 40) begin
        refA = 12'(na); refB = 12'(nb); refC = 12'(nc); scale = 8'(nsc);
        sampleStrobe = 1'b1;
      end else begin
        sampleStrobe = 1'b0;
      end
      @(negedge clk);
    end
    sampleStrobe = 1'b0;
  endtask

  task automatic runPair(input int a, input int b, input int c, input bit linear);
    int r[3], t[3], w[3];
    int wA[3], fA[3], lA[3], sA, wB[3], fB[3], lB[3], sB;
    r[0] = a; r[1] = b; r[2] = c;
    calcTimes(r, int'(scale), int'(periodLen), t, w);
    strobeRefs(a, b, c);
    measure(wA, fA, lA, sA, 1'b0, 0, 0, 0, 0);
    measure(wB, fB, lB, sB, 1'b0, 0, 0, 0, 0);
    check(sA != sB, "R7", "pair alternates sequence", sB, 1 - sA);
    for (int i = 0; i < 3; i++) begin
      check(wA[i] == w[i], "R3", "pulse width", wA[i], w[i]);
      check(wB[i] == wA[i], "R6", "pair widths symmetric", wB[i], wA[i]);
      if (sA == 0) begin
        check(fA[i] == int'(w[i] > 0), "R5", "falling seq high at start", fA[i], int'(w[i] > 0));
        check(lB[i] == int'(w[i] > 0), "R6", "rising seq high at end", lB[i], int'(w[i] > 0));
      end else begin
        check(fB[i] == int'(w[i] > 0), "R5", "falling seq high at start", fB[i], int'(w[i] > 0));
        check(lA[i] == int'(w[i] > 0), "R6", "rising seq high at end", lA[i], int'(w[i] > 0));
      end
    end
    if (linear) begin
      check(wA[0] - wA[1] == t[0] - t[1], "R2", "width diff A-B", wA[0] - wA[1], t[0] - t[1]);
      check(wA[2] - wA[1] == t[2] - t[1], "R2", "width diff C-B", wA[2] - wA[1], t[2] - t[1]);
    end
  endtask

  initial begin
    int w[3], f[3], l[3], s;
    int steps;
    logic prevSeq;
    repeat (4) @(negedge clk);
    check(gateA == 1'b0 && gateB == 1'b0 && gateC == 1'b0, "R1", "all gates low in reset",
          int'({gateC, gateB, gateA}), 0);
    check(seqOn == 1'b0, "R1", "seqOn low in reset", int'(seqOn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(seqOn == 1'b0, "R1", "first period is falling sequence", int'(seqOn), 0);

    // Linear range, positive and negative references
    runPair(60, -40, 0, 1'b1);
    scale = 8'd100;
    runPair(-100, 20, 80, 1'b1);

    // Overmodulation: widths clamp to P and 0
    scale = 8'd255;
    runPair(2000, -2000, 0, 1'b0);
    measure(w, f, l, s, 1'b0, 0, 0, 0, 0);
    check(w[0] == 100, "R4", "clamp to period", w[0], 100);
    check(w[1] == 0, "R4", "clamp to zero", w[1], 0);

    // Strobe and scale change mid-period leave that period alone
    measure(w, f, l, s, 1'b1, 60, -40, 0, 128);
    check(w[0] == 100 && w[1] == 0 && w[2] == 50, "R8", "mid-period strobe ignored (A)", w[0], 100);
    check(w[2] == 50, "R8", "mid-period strobe ignored (C)", w[2], 50);
    measure(w, f, l, s, 1'b0, 0, 0, 0, 0);
    check(w[0] == 75, "R8", "new refs at next boundary (A)", w[0], 75);
    check(w[1] == 25, "R8", "new refs at next boundary (B)", w[1], 25);
    check(w[2] == 45, "R8", "new refs at next boundary (C)", w[2], 45);

    // Period length change mid-period
    while (mCount != 10) @(negedge clk);
    periodLen = 12'd64;
    prevSeq = seqOn; steps = 0;
    while (seqOn == prevSeq && steps < 1000) begin @(negedge clk); steps++; end
    check(steps == 90, "R8", "current period keeps old length", steps, 90);
    prevSeq = seqOn; steps = 0;
    while (seqOn == prevSeq && steps < 1000) begin @(negedge clk); steps++; end
    check(steps == 64, "R9", "new period length", steps, 64);
    measure(w, f, l, s, 1'b0, 0, 0, 0, 0);
    check(w[0] == 57 && w[1] == 7, "R3", "widths centred in shorter period", w[0], 57);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule